// File: doc/BRIEF.md
# Dual-Bank Infrared Event Interrupt Controller

This block collects the status events of an infrared link controller into one interrupt line. The link controller has two operating families: a slow, UART-style serial mode and a fast, framed mode. Each family owns its own event bank of five sticky pending bits. Each bank has a mask word and a write-one-to-clear word. A mode register holds one gate bit per bank, a FIFO-receive mask bit and a 2-bit transfer-mode field. Software normally opens only the gate of the bank that matches the selected transfer mode and leaves the other bank blocked.

The line-coding logic raises single-cycle event pulses on `ev_slow_i` and `ev_fast_i`. The vector index of a pulse selects its bit in the 16-bit register view. Two of the five bits change meaning with the bank. In the slow bank they flag a receive timeout and a framing error. In the fast bank they flag an abort and a CRC error. Reads are combinational from the address. Writes take effect at the clock edge.

Top module: `ir_intc`

## Requirements
- R1: After reset, every pending bit reads 0, both mask words read 0x8B80, the mode word reads 0x0111 (both gates, FIFO mask set, transfer mode 0), and `irq_o` is low.
- R2: A pulse on event index 0, 1, 2, 3 or 4 of a bank sets bit 7, 8, 9, 11 or 15 of that bank's source word on the next edge. The bit then stays set until it is cleared.
- R3: Writing the clear word (address 3 for the slow bank, 6 for the fast bank) removes each pending bit written as 1 and leaves bits written as 0 alone. A clear word always reads 0.
- R4: When an event pulse and a clear of the same bit meet in one cycle, the bit stays pending.
- R5: A mask bit at 1 keeps its pending event off `irq_o`. A mask bit at 0 lets it through. The mask words sit at address 2 (slow) and 5 (fast).
- R6: Mode bit 0 gates the slow bank and mode bit 4 gates the fast bank. A gate at 1 blocks every event of its bank. `irq_o` is high exactly when some open bank has an unmasked pending bit.
- R7: The mode word at address 0 stores bits 15:14 (transfer mode: 0 slow, 2 fast framed, 3 medium), bit 8 (FIFO-receive mask), and bits 4 and 0. Its other bits read 0. Bits 15:14 drive `xfer_mode_o` and bit 8 drives `fifo_rx_mask_o`.
- R8: Writes to a source word (address 1 slow, 4 fast) have no effect.
- R9: Mask words hold only bits 15, 11, 9, 8 and 7. All other bits read 0. Address 7 reads 0.
- R10: Events, masks and clears of one bank never change the other bank's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| ev_slow_i | input | 5 | Slow-bank event pulses (index 0..4 to bits 7,8,9,11,15) |
| ev_fast_i | input | 5 | Fast-bank event pulses (same mapping) |
| irq_o | output | 1 | Combined interrupt |
| xfer_mode_o | output | 2 | Transfer-mode field of the mode word |
| fifo_rx_mask_o | output | 1 | FIFO-receive mask bit of the mode word |

## Verification
The bench builds the block with its default 3-bit address. This makes all eight word addresses, including the unmapped one, reachable from the port. Both banks are present, so independence between banks and the per-bank gates can be tested against each other. Directed phases cover single events, partial clears, event-versus-clear collisions, reserved bits and read-only writes. A random phase follows, and a behavioural model checks every cycle.

// File: rtl/ir_intc_pkg.sv
// Package: shared constants, types and bit-mapping helpers of the
// infrared interrupt controller. Assumes 16-bit register words.
package ir_intc_pkg;

    localparam int DATA_W       = 16;
    localparam int EVT_N        = 5;
    localparam int NB           = 2;
    localparam int GATE_STRIDE  = 4;
    localparam int FIFO_MSK_POS = 8;
    localparam int XM_LSB       = 14;
    localparam int MODE_ADDR    = 0;
    localparam int BANK_STRIDE  = 3;

    typedef enum logic [1:0] {
        XM_SLOW = 2'd0,
        XM_RSVD = 2'd1,
        XM_FAST = 2'd2,
        XM_MED  = 2'd3
    } xfer_mode_e;

    // Word bit position of event index k
    function automatic int evt_pos(input int k);
        case (k)
            0:       return 7;
            1:       return 8;
            2:       return 9;
            3:       return 11;
            default: return 15;
        endcase
    endfunction

    // Source word address of bank b (mask follows, then clear)
    function automatic int bank_base(input int b);
        return 1 + BANK_STRIDE * b;
    endfunction

    // Spread an event vector to its register word positions
    function automatic logic [DATA_W-1:0] evt_to_word(input logic [EVT_N-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int k = 0; k < EVT_N; k++) w[evt_pos(k)] = v[k];
        return w;
    endfunction

    // Gather the event positions of a register word
    function automatic logic [EVT_N-1:0] word_to_evt(input logic [DATA_W-1:0] w);
        logic [EVT_N-1:0] v;
        for (int k = 0; k < EVT_N; k++) v[k] = w[evt_pos(k)];
        return v;
    endfunction

endpackage

// File: rtl/ir_evt_bank.sv
// Module: one event bank with sticky pending bits, a mask and a
// write-one-to-clear port. Assumes the write bits are already gathered
// to event order; an event in the same cycle as its clear wins.
module ir_evt_bank
    import ir_intc_pkg::*;
#(
    parameter int AW       = 3,
    parameter int SRC_ADDR = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_i,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [EVT_N-1:0] wbits_i,
    output logic [EVT_N-1:0] pend_o,
    output logic [EVT_N-1:0] mask_o
);

    localparam logic [AW-1:0] MASK_A = AW'(SRC_ADDR + 1);
    localparam logic [AW-1:0] CLR_A  = AW'(SRC_ADDR + 2);

    logic             wr_mask;
    logic [EVT_N-1:0] clr_bits;

    // Decode the bank's own write targets
    always_comb begin
        wr_mask  = wr_i && (addr_i == MASK_A);
        clr_bits = (wr_i && (addr_i == CLR_A)) ? wbits_i : '0;
    end

    // Pending bits: clear first, then new events on top
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_bits) | evt_i;
    end

    // Mask word: all blocked out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_o <= '1;
        else if (wr_mask) mask_o <= wbits_i;
    end

endmodule

// File: rtl/ir_mode_reg.sv
// Module: mode word holding one gate per bank, the FIFO-receive mask and
// the transfer-mode field. Assumes gate of bank b sits at bit b*GATE_STRIDE.
module ir_mode_reg
    import ir_intc_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NB-1:0]     gate_o,
    output logic              fifo_msk_o,
    output xfer_mode_e        xmode_o,
    output logic [DATA_W-1:0] word_o
);

    localparam logic [AW-1:0] MODE_A = AW'(MODE_ADDR);

    logic wr_mode;
    logic unused_wd;

    // Mode write decode; unassigned write bits are dropped
    assign wr_mode   = wr_i && (addr_i == MODE_A);
    assign unused_wd = ^wdata_i;

    for (genvar b = 0; b < NB; b++) begin : g_gate
        // Per-bank gate bit, blocked out of reset
        always_ff @(posedge clk) begin
            if (!rst_n)       gate_o[b] <= 1'b1;
            else if (wr_mode) gate_o[b] <= wdata_i[b*GATE_STRIDE];
        end
    end

    // FIFO-receive mask and transfer-mode field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_msk_o <= 1'b1;
            xmode_o    <= XM_SLOW;
        end else if (wr_mode) begin
            fifo_msk_o <= wdata_i[FIFO_MSK_POS];
            xmode_o    <= xfer_mode_e'(wdata_i[XM_LSB+1:XM_LSB]);
        end
    end

    // Assemble the readable word
    always_comb begin
        word_o = '0;
        for (int b = 0; b < NB; b++) word_o[b*GATE_STRIDE] = gate_o[b];
        word_o[FIFO_MSK_POS]        = fifo_msk_o;
        word_o[XM_LSB+1:XM_LSB]     = xmode_o;
    end

endmodule

// File: rtl/ir_irq_merge.sv
// Module: reduces the unmasked pending events of all open banks to one
// interrupt line. Purely combinational; assumes gate 1 means blocked.
module ir_irq_merge
    import ir_intc_pkg::*;
#(
    parameter int BANKS = NB
) (
    input  logic [BANKS-1:0][EVT_N-1:0] pend_i,
    input  logic [BANKS-1:0][EVT_N-1:0] mask_i,
    input  logic [BANKS-1:0]            gate_i,
    output logic                        irq_o
);

    logic [BANKS-1:0] req_b;

    for (genvar b = 0; b < BANKS; b++) begin : g_req
        // Bank request: any unmasked pending bit while the gate is open
        assign req_b[b] = (|(pend_i[b] & ~mask_i[b])) & ~gate_i[b];
    end

    // Combine all bank requests
    assign irq_o = |req_b;

endmodule

// File: rtl/ir_intc.sv
// Module: top of the dual-bank infrared interrupt controller. Bank 0 is
// the slow serial bank, bank 1 the fast framed bank. Reads are
// combinational on the address; writes land at the clock edge.
module ir_intc
    import ir_intc_pkg::*;
#(
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    input  logic [4:0]        ev_slow_i,
    input  logic [4:0]        ev_fast_i,
    output logic              irq_o,
    output logic [1:0]        xfer_mode_o,
    output logic              fifo_rx_mask_o
);

    logic [NB-1:0][EVT_N-1:0] evt_b;
    logic [NB-1:0][EVT_N-1:0] pend_b;
    logic [NB-1:0][EVT_N-1:0] msk_b;
    logic [NB-1:0]            gate_b;
    logic [EVT_N-1:0]         wbits;
    logic [DATA_W-1:0]        mode_word;
    xfer_mode_e               xmode;

    // Route bank event inputs and gather write bits to event order
    assign evt_b[0] = ev_slow_i;
    assign evt_b[1] = ev_fast_i;
    assign wbits    = word_to_evt(reg_wdata_i);

    ir_mode_reg #(.AW(REG_AW)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .gate_o     (gate_b),
        .fifo_msk_o (fifo_rx_mask_o),
        .xmode_o    (xmode),
        .word_o     (mode_word)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        ir_evt_bank #(.AW(REG_AW), .SRC_ADDR(bank_base(b))) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_b[b]),
            .wr_i    (reg_wr_i),
            .addr_i  (reg_addr_i),
            .wbits_i (wbits),
            .pend_o  (pend_b[b]),
            .mask_o  (msk_b[b])
        );
    end

    ir_irq_merge #(.BANKS(NB)) u_merge (
        .pend_i (pend_b),
        .mask_i (msk_b),
        .gate_i (gate_b),
        .irq_o  (irq_o)
    );

    assign xfer_mode_o = xmode;

    // Read mux: mode word, then per-bank source / mask / clear words
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == REG_AW'(MODE_ADDR)) reg_rdata_o = mode_word;
        for (int b = 0; b < NB; b++) begin
            if (reg_addr_i == REG_AW'(bank_base(b)))
                reg_rdata_o = evt_to_word(pend_b[b]);
            if (reg_addr_i == REG_AW'(bank_base(b) + 1))
                reg_rdata_o = evt_to_word(msk_b[b]);
        end
    end

endmodule

// File: rtl/ir_intc_chk.sv
// Module: property checker for ir_intc, attached by bind below.
// Assumes bank 0 is slow and bank 1 is fast, as in the top.
module ir_intc_chk
    import ir_intc_pkg::*;
#(
    parameter int REG_AW = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr_i,
    input logic [REG_AW-1:0]        reg_addr_i,
    input logic [EVT_N-1:0]         wbits,
    input logic [EVT_N-1:0]         ev_slow_i,
    input logic [NB-1:0][EVT_N-1:0] pend_b,
    input logic [NB-1:0][EVT_N-1:0] msk_b,
    input logic [NB-1:0]            gate_b,
    input logic                     irq_o
);

    localparam logic [REG_AW-1:0] SRC0 = REG_AW'(bank_base(0));
    localparam logic [REG_AW-1:0] CLR0 = REG_AW'(bank_base(0) + 2);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && pend_b == '0)); // R1

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_slow_i) |=> ((pend_b[0] & $past(ev_slow_i)) == $past(ev_slow_i))); // R2

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == CLR0) |=> ((pend_b[0] & $past(wbits) & ~$past(ev_slow_i)) == '0)); // R3

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == CLR0 && (|(wbits & ev_slow_i)))
        |=> ((pend_b[0] & $past(wbits & ev_slow_i)) == $past(wbits & ev_slow_i))); // R4

    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&msk_b) |-> !irq_o); // R5

    AST_GATES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&gate_b) |-> !irq_o); // R6

    AST_SRC_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == SRC0 && ev_slow_i == '0) |=> $stable(pend_b[0])); // R8

endmodule

bind ir_intc ir_intc_chk #(.REG_AW(REG_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .wbits      (wbits),
    .ev_slow_i  (ev_slow_i),
    .pend_b     (pend_b),
    .msk_b      (msk_b),
    .gate_b     (gate_b),
    .irq_o      (irq_o)
);

// File: tb/ir_intc_bench.sv
module ir_intc_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] EVT_BITS  = 16'h8B80;
    localparam logic [15:0] MODE_BITS = 16'hC111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [4:0]  evs = '0;
    logic [4:0]  evf = '0;
    logic [15:0] rdata;
    logic        irq;
    logic [1:0]  xmode;
    logic        fifo_msk;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [15:0] m_mode;
    logic [15:0] m_pend [2];
    logic [15:0] m_mask [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_intc u_ir_intc (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr_i       (wr),
        .reg_addr_i     (addr),
        .reg_wdata_i    (wdata),
        .reg_rdata_o    (rdata),
        .ev_slow_i      (evs),
        .ev_fast_i      (evf),
        .irq_o          (irq),
        .xfer_mode_o    (xmode),
        .fifo_rx_mask_o (fifo_msk)
    );

    function automatic logic [15:0] spread(input logic [4:0] v);
        int pos [5] = '{7, 8, 9, 11, 15};
        logic [15:0] w = '0;
        foreach (pos[i]) if (v[i]) w[pos[i]] = 1'b1;
        return w;
    endfunction

    function automatic logic [15:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_mode;
            3'd1: return m_pend[0];
            3'd2: return m_mask[0];
            3'd4: return m_pend[1];
            3'd5: return m_mask[1];
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic exp_irq();
        logic s = ((m_pend[0] & ~m_mask[0]) != 0) && !m_mode[0];
        logic f = ((m_pend[1] & ~m_mask[1]) != 0) && !m_mode[4];
        return s || f;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One clock: update the model from the driven inputs, then compare
    task automatic tick(input string req);
        @(posedge clk);
        if (!rst_n) begin
            m_mode = 16'h0111;
            m_pend = '{16'h0, 16'h0};
            m_mask = '{EVT_BITS, EVT_BITS};
        end else begin
            if (wr) begin
                case (addr)
                    3'd0: m_mode = wdata & MODE_BITS;
                    3'd2: m_mask[0] = wdata & EVT_BITS;
                    3'd3: m_pend[0] = m_pend[0] & ~(wdata & EVT_BITS);
                    3'd5: m_mask[1] = wdata & EVT_BITS;
                    3'd6: m_pend[1] = m_pend[1] & ~(wdata & EVT_BITS);
                    default: ;
                endcase
            end
            m_pend[0] = m_pend[0] | spread(evs);
            m_pend[1] = m_pend[1] | spread(evf);
        end
        @(negedge clk);
        check(req, "rdata", int'(rdata), int'(exp_read(addr)));
        check(req, "irq", int'(irq), int'(exp_irq()));
        check(req, "xfer_mode", int'(xmode), int'(m_mode[15:14]));
        check(req, "fifo_mask", int'(fifo_msk), int'(m_mode[8]));
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d, input string req);
        wr = 1'b1; addr = a; wdata = d;
        tick(req);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, input string req);
        addr = a;
        tick(req);
    endtask

    task automatic pulse(input logic [4:0] s, input logic [4:0] f, input string req);
        evs = s; evf = f;
        tick(req);
        evs = '0; evf = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        repeat (3) tick("R1");
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd_reg(3'(a), "R1");

        // R2: each slow event sets its own bit and stays set
        wr_reg(3'd0, 16'h0110, "R6");
        wr_reg(3'd2, 16'h0000, "R5");
        addr = 3'd1;
        for (int k = 0; k < 5; k++) begin
            pulse(5'(1 << k), 5'h0, "R2");
            tick("R2");
            wr_reg(3'd3, 16'hFFFF, "R3");
            addr = 3'd1;
            tick("R3");
        end

        // R5: partial masking
        wr_reg(3'd2, 16'h8B00, "R5");
        addr = 3'd1;
        pulse(5'b00001, 5'h0, "R5");
        tick("R5");
        pulse(5'b00100, 5'h0, "R5");
        tick("R5");

        // R3: partial clear leaves bits written as 0
        wr_reg(3'd3, 16'h0200, "R3");
        addr = 3'd1; tick("R3");
        wr_reg(3'd3, 16'h0080, "R3");
        rd_reg(3'd3, "R3");

        // R4: event and clear of the same bit in one cycle
        evs = 5'b10000;
        wr_reg(3'd3, 16'h8000, "R4");
        evs = '0;
        rd_reg(3'd1, "R4");
        wr_reg(3'd2, 16'h0000, "R4");
        tick("R4");

        // R6: gates
        wr_reg(3'd0, 16'h0111, "R6");
        tick("R6");
        wr_reg(3'd0, 16'h0101, "R6");
        wr_reg(3'd5, 16'h0000, "R6");
        pulse(5'h0, 5'b01000, "R6");
        tick("R6");
        wr_reg(3'd0, 16'h0011, "R6");
        tick("R6");

        // R7: mode word fields
        wr_reg(3'd0, 16'hFFFF, "R7");
        rd_reg(3'd0, "R7");
        wr_reg(3'd0, 16'h8000, "R7");
        rd_reg(3'd0, "R7");
        wr_reg(3'd0, 16'h4000, "R7");
        rd_reg(3'd0, "R7");

        // R8: source words are read-only
        wr_reg(3'd1, 16'hFFFF, "R8");
        rd_reg(3'd1, "R8");
        wr_reg(3'd4, 16'h0000, "R8");
        rd_reg(3'd4, "R8");

        // R9: reserved mask bits and unmapped address
        wr_reg(3'd2, 16'hFFFF, "R9");
        rd_reg(3'd2, "R9");
        wr_reg(3'd5, 16'h7477, "R9");
        rd_reg(3'd5, "R9");
        wr_reg(3'd7, 16'hFFFF, "R9");
        rd_reg(3'd7, "R9");

        // R10: fast activity leaves the slow bank alone, then random mix
        wr_reg(3'd3, 16'hFFFF, "R10");
        pulse(5'h0, 5'h1F, "R10");
        rd_reg(3'd1, "R10");
        wr_reg(3'd6, 16'hFFFF, "R10");
        rd_reg(3'd4, "R10");
        for (int i = 0; i < 400; i++) begin
            wr    = ($urandom % 3) == 0;
            addr  = 3'($urandom);
            wdata = 16'($urandom);
            evs   = (($urandom % 4) == 0) ? 5'($urandom) : 5'h0;
            evf   = (($urandom % 4) == 0) ? 5'($urandom) : 5'h0;
            tick("R10");
        end
        wr = 1'b0; evs = '0; evf = '0;
        tick("R10");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule